// File: doc/BRIEF.md
# Branch Condition Evaluation Unit

This block takes one branch control word per cycle and works out whether control flow is redirected and to which program counter. It accepts two encodings, picked by a format select. The compact form is 16 bits wide. The extended form is 48 bits wide and carries a 23-bit offset and a 16-bit truth table. Four single-bit condition inputs, called A, B, C and D, feed the decision.

The operation field does more than select a branch. It can also ask for a fragment discard, a wait that loops while the tile buffer is not ready, or a write-out that retries by branching back when it fails. The block raises a one-cycle pulse for each of these requests. It does not perform any of the side effects itself. All outputs are registered and appear one cycle after the valid input.

Top module: `branch_cond_unit`

## Requirements
- R1: Operation value 1 (bits [2:0]) in compact format is an unconditional branch. It is always taken and its offset is the 7-bit field in bits [15:9].
- R2: For every other legal operation in compact format, the offset is bits [13:7] and a condition code sits in bits [15:14]. The codes are: 0 never, 1 taken when A is 0, 2 taken when A is 1, 3 always. Only A is examined.
- R3: In extended format (i_ext=1), every legal operation takes its condition from table bits [47:32]. The table is indexed by {D,C,B,A}, with A in i_cond[0] as the least significant bit.
- R4: o_target equals i_pc plus the sign-extended offset, counted in instruction words. The extended offset is bits [31:9]. o_tag carries bits [6:3].
- R5: Operation 4 (discard) pulses o_discard when its condition holds and is never taken.
- R6: Operation 6 (tile-buffer wait) is taken when its condition holds and pulses o_tile_wait in the same cycle.
- R7: Operation 7 (write-out) pulses o_wrout every time it is issued. It is taken (retry) only when its condition holds.
- R8: Operation values 0, 3 and 5 raise o_illegal and produce no taken branch and no pulse.
- R9: Outputs follow an accepted word by exactly one cycle. In a cycle after no valid word, o_valid, o_taken and every pulse are low, while o_target and o_tag keep their previous values.
- R10: During reset every output is zero.
- R11: In compact format, word bits [47:16] have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_valid | input | 1 | Branch word present this cycle |
| i_ext | input | 1 | 1 selects extended format, 0 compact |
| i_word | input | 48 | Branch control word (compact uses bits [15:0]) |
| i_pc | input | PC_W | Program counter of the branch |
| i_cond | input | 4 | Condition bits {D,C,B,A} |
| o_valid | output | 1 | Result valid |
| o_taken | output | 1 | Branch taken |
| o_target | output | PC_W | Branch target program counter |
| o_tag | output | 4 | Destination tag |
| o_discard | output | 1 | Discard request pulse |
| o_tile_wait | output | 1 | Tile-buffer wait pulse |
| o_wrout | output | 1 | Write-out request pulse |
| o_illegal | output | 1 | Reserved operation seen |

## Verification
A write-out whose condition holds raises both the write-out request and the taken retry branch in the same cycle. The tile-buffer wait likewise pairs its pulse with a taken branch. The bench drives write-out words with A set and with A clear, and it drives wait words both ways. A behavioural model predicts every output independently, and the bench compares the two every cycle, so a missing pulse or a missing branch in a shared cycle is reported.

// File: rtl/branch_cond_unit.sv
module branch_cond_unit #(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            i_valid,
  input  logic            i_ext,
  input  logic [47:0]     i_word,
  input  logic [PC_W-1:0] i_pc,
  input  logic [3:0]      i_cond,
  output logic            o_valid,
  output logic            o_taken,
  output logic [PC_W-1:0] o_target,
  output logic [3:0]      o_tag,
  output logic            o_discard,
  output logic            o_tile_wait,
  output logic            o_wrout,
  output logic            o_illegal
);
  localparam int SOFF_W = 7;
  localparam int LOFF_W = 23;

  logic [2:0]        op;
  logic [SOFF_W-1:0] soff;
  logic [LOFF_W-1:0] loff;
  logic [1:0]        cc;
  logic [15:0]       tbl;
  logic [PC_W-1:0]   off_ext;
  logic              cc_ok, cond_ok, bad_op, br_op;

  assign op   = i_word[2:0];
  assign cc   = i_word[15:14];
  assign tbl  = i_word[47:32];
  assign loff = i_word[31:9];
  assign soff = (op == 3'd1) ? i_word[15:9] : i_word[13:7];

  assign off_ext = i_ext ? {{(PC_W-LOFF_W){loff[LOFF_W-1]}}, loff}
                         : {{(PC_W-SOFF_W){soff[SOFF_W-1]}}, soff};

  always_comb begin
    case (cc)
      2'd1:    cc_ok = ~i_cond[0];
      2'd2:    cc_ok = i_cond[0];
      2'd3:    cc_ok = 1'b1;
      default: cc_ok = 1'b0;
    endcase
  end

  assign cond_ok = i_ext ? tbl[i_cond] : ((op == 3'd1) | cc_ok);
  assign bad_op  = (op == 3'd0) | (op == 3'd3) | (op == 3'd5);
  assign br_op   = (op == 3'd1) | (op == 3'd2) | (op == 3'd6) | (op == 3'd7);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_valid     <= 1'b0;
      o_taken     <= 1'b0;
      o_target    <= '0;
      o_tag       <= '0;
      o_discard   <= 1'b0;
      o_tile_wait <= 1'b0;
      o_wrout     <= 1'b0;
      o_illegal   <= 1'b0;
    end else begin
      o_valid     <= i_valid;
      o_taken     <= i_valid & br_op & cond_ok;
      o_discard   <= i_valid & (op == 3'd4) & cond_ok;
      o_tile_wait <= i_valid & (op == 3'd6) & cond_ok;
      o_wrout     <= i_valid & (op == 3'd7);
      o_illegal   <= i_valid & bad_op;
      if (i_valid) begin
        o_target <= i_pc + off_ext;
        o_tag    <= i_word[6:3];
      end
    end
  end

  p_discard_not_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
    o_discard |-> !o_taken);

  p_illegal_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    o_illegal |-> !o_taken && !o_discard && !o_tile_wait && !o_wrout);

  p_one_request_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({o_discard, o_tile_wait, o_wrout, o_illegal}));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !i_valid |=> !o_valid && !o_taken && !o_wrout && !o_discard);

  p_hold_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !i_valid |=> $stable(o_target) && $stable(o_tag));

  p_uncond_taken_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (i_valid && !i_ext && i_word[2:0] == 3'd1) |=> o_taken);

  p_wrout_issue_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (i_valid && i_word[2:0] == 3'd7) |=> o_wrout);
endmodule

// File: tb/branch_cond_unit_test.sv
module branch_cond_unit_test;
  localparam int CLK_P = 10;
  localparam int PC_W  = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            i_valid, i_ext;
  logic [47:0]     i_word;
  logic [PC_W-1:0] i_pc;
  logic [3:0]      i_cond;
  logic            o_valid, o_taken, o_discard, o_tile_wait, o_wrout, o_illegal;
  logic [PC_W-1:0] o_target;
  logic [3:0]      o_tag;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic            e_valid, e_taken, e_discard, e_wait, e_wrout, e_illegal;
  logic [PC_W-1:0] e_target;
  logic [3:0]      e_tag;
  string           e_req;

  always #(CLK_P/2) clk = ~clk;

  branch_cond_unit #(.PC_W(PC_W)) uut (
    .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_ext(i_ext), .i_word(i_word),
    .i_pc(i_pc), .i_cond(i_cond), .o_valid(o_valid), .o_taken(o_taken),
    .o_target(o_target), .o_tag(o_tag), .o_discard(o_discard),
    .o_tile_wait(o_tile_wait), .o_wrout(o_wrout), .o_illegal(o_illegal));

  function automatic logic [47:0] mk_u(input int tag, input int off);
    logic [47:0] w = '0;
    w[2:0] = 3'd1; w[6:3] = tag[3:0]; w[15:9] = off[6:0];
    return w;
  endfunction

  function automatic logic [47:0] mk_c(input int op, input int tag, input int off, input int cc);
    logic [47:0] w = '0;
    w[2:0] = op[2:0]; w[6:3] = tag[3:0]; w[13:7] = off[6:0]; w[15:14] = cc[1:0];
    return w;
  endfunction

  function automatic logic [47:0] mk_x(input int op, input int tag, input int off, input int tbl);
    logic [47:0] w = '0;
    w[2:0] = op[2:0]; w[6:3] = tag[3:0]; w[31:9] = off[22:0]; w[47:32] = tbl[15:0];
    return w;
  endfunction

  task automatic cmp1(input string nm, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", e_req, nm, act, exp);
    end
  endtask

  task automatic compare_all();
    cmp1("valid", o_valid, e_valid);
    cmp1("taken", o_taken, e_taken);
    cmp1("target", o_target, e_target);
    cmp1("tag", o_tag, e_tag);
    cmp1("discard", o_discard, e_discard);
    cmp1("tile_wait", o_tile_wait, e_wait);
    cmp1("wrout", o_wrout, e_wrout);
    cmp1("illegal", o_illegal, e_illegal);
  endtask

  task automatic step(input bit v, input bit e, input logic [47:0] w,
                      input int pc, input int cnd, input string req);
    int op, off, cc;
    bit ok;
    @(negedge clk);
    compare_all();
    i_valid = v; i_ext = e; i_word = w; i_pc = pc; i_cond = cnd[3:0];
    e_req = req;
    op = w[2:0];
    if (e) begin
      ok = ((w[47:32] >> cnd) & 1) != 0;
      off = w[31:9];
      if (off >= (1 << 22)) off -= (1 << 23);
    end else begin
      cc = w[15:14];
      if (op == 1) ok = 1;
      else if (cc == 3) ok = 1;
      else if (cc == 2) ok = (cnd & 1) == 1;
      else if (cc == 1) ok = (cnd & 1) == 0;
      else ok = 0;
      off = (op == 1) ? int'(w[15:9]) : int'(w[13:7]);
      if (off >= 64) off -= 128;
    end
    e_valid   = v;
    e_taken   = v && ok && (op == 1 || op == 2 || op == 6 || op == 7);
    e_discard = v && ok && op == 4;
    e_wait    = v && ok && op == 6;
    e_wrout   = v && op == 7;
    e_illegal = v && (op == 0 || op == 3 || op == 5);
    if (v) begin
      e_target = PC_W'(longint'(pc) + longint'(off));
      e_tag    = w[6:3];
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; i_valid = 0; i_ext = 0; i_word = '0; i_pc = '0; i_cond = '0;
    e_valid = 0; e_taken = 0; e_discard = 0; e_wait = 0; e_wrout = 0; e_illegal = 0;
    e_target = '0; e_tag = '0; e_req = "R10 reset";
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare_all();
    rst_n = 1;
    // R1 R4 unconditional, forward and backward
    step(1, 0, mk_u(5, 5), 100, 0, "R1 uncond fwd");
    step(1, 0, mk_u(9, 7'h40), 100, 15, "R4 uncond -64");
    // R2 condition codes, only A examined
    step(1, 0, mk_c(2, 1, 3, 1), 200, 4'b1110, "R2 cc1 A=0");
    step(1, 0, mk_c(2, 1, 3, 1), 200, 4'b0001, "R2 cc1 A=1");
    step(1, 0, mk_c(2, 2, 7'h7F, 2), 200, 4'b0001, "R2 cc2 A=1");
    step(1, 0, mk_c(2, 2, 7'h7F, 2), 200, 4'b1110, "R2 cc2 A=0");
    step(1, 0, mk_c(2, 3, 10, 3), 300, 0, "R2 cc3");
    step(1, 0, mk_c(2, 3, 10, 0), 300, 15, "R2 cc0");
    // R3 extended truth table
    step(1, 1, mk_x(2, 4, 1000, 16'h8000), 400, 15, "R3 tbl idx15");
    step(1, 1, mk_x(2, 4, 1000, 16'h8000), 400, 7, "R3 tbl idx7");
    step(1, 1, mk_x(1, 5, 2, 16'h0020), 400, 5, "R3 tbl idx5");
    step(1, 1, mk_x(1, 5, 2, 16'h0020), 400, 10, "R3 tbl idx10");
    step(1, 1, mk_x(2, 6, 23'h400000, 16'hFFFF), 32'h0050_0000, 0, "R4 ext -2^22");
    // R5 discard
    step(1, 0, mk_c(4, 7, 1, 3), 500, 0, "R5 discard hit");
    step(1, 0, mk_c(4, 7, 1, 2), 500, 0, "R5 discard miss");
    step(1, 1, mk_x(4, 7, 1, 16'h0002), 500, 1, "R5 discard ext");
    // R6 tile-buffer wait
    step(1, 0, mk_c(6, 8, 7'h7F, 2), 600, 1, "R6 wait busy");
    step(1, 0, mk_c(6, 8, 7'h7F, 2), 600, 0, "R6 wait ready");
    // R7 write-out with retry, same-cycle request and branch
    step(1, 0, mk_c(7, 9, 0, 2), 700, 1, "R7 wrout retry");
    step(1, 0, mk_c(7, 9, 0, 2), 700, 0, "R7 wrout done");
    step(1, 1, mk_x(7, 9, 0, 16'h0001), 700, 0, "R7 wrout ext");
    // R8 reserved ops
    step(1, 1, mk_x(0, 1, 3, 16'hFFFF), 800, 3, "R8 op0");
    step(1, 0, mk_c(3, 1, 3, 3), 800, 3, "R8 op3");
    step(1, 1, mk_x(5, 1, 3, 16'hFFFF), 800, 3, "R8 op5");
    // R9 idle cycles hold target and clear flags
    step(1, 0, mk_u(12, 20), 900, 0, "R9 before idle");
    step(0, 0, mk_u(3, 1), 5, 0, "R9 idle1");
    step(0, 1, mk_x(7, 3, 1, 16'hFFFF), 5, 15, "R9 idle2");
    // R11 compact ignores upper bits
    step(1, 0, mk_c(2, 10, 4, 2) | 48'hFFFF_FFFF_0000, 1000, 1, "R11 upper ones");
    step(1, 0, mk_c(7, 11, 4, 1) | 48'h5A5A_A5A5_0000, 1000, 1, "R11 upper mix");
    for (int k = 0; k < 64; k++)
      step(1, k[0], {k[15:0], 16'(k * 37), 16'(k * 91)}, k * 17, k % 16, "R3 sweep");
    step(0, 0, '0, 0, 0, "R9 tail");
    step(0, 0, '0, 0, 0, "R9 end");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule